// File: doc/BRIEF.md
# Bitmap Glyph Colour Renderer

This block draws one 32x32 monochrome character cell on a display controller that takes a command/data byte stream. After a start request it latches the cell position (x, y) and a 24-bit foreground colour. It then emits two address-window commands, one for columns and one for rows, each followed by its start and end coordinates. Next comes the memory-write command. The block then streams the pixels of the cell.

The glyph bitmap is held outside the block and is read one byte at a time through an address/data port. The port has one cycle of read latency. Every bitmap bit becomes one pixel of three bytes: the foreground colour when the bit is set, black when it is clear.

Bytes leave on a valid/ready handshake with a flag that marks command bytes. A single-cycle done pulse closes the run. A serializer downstream turns the bytes into wire traffic.

Top module: `glyph_expander`

## Requirements
- R1: After reset the block is idle (busy, outValid and doneStrobe low). A startReq seen while idle latches posX, posY and fgColor. The next cycle presents command byte 0x2A with outIsData=0.
- R2: Four data bytes (outIsData=1) follow command 0x2A: posX high byte, posX low byte, then the high and low bytes of posX+31, computed modulo 2^16.
- R3: Command 0x2B follows, then four data bytes: posY high, posY low, (posY+31) high and (posY+31) low, computed modulo 2^16.
- R4: Command 0x2C follows the row window. After it come exactly 3072 data bytes and no further command byte.
- R5: The glyph is read at romAddr 0 to 127 in ascending order, with romData valid one cycle after the address is presented. Bytes 4r to 4r+3 form glyph row r, left to right.
- R6: Within a glyph byte, bit 0 gives the leftmost of its 8 pixels and bit 7 the rightmost. Each pixel is emitted before the next.
- R7: A set bit emits fgColor[23:16], fgColor[15:8] and fgColor[7:0], in that order.
- R8: A clear bit emits three 0x00 bytes.
- R9: A byte transfers on a clock edge where outValid and outReady are both high. While outValid is high and outReady low, outValid, outByte and outIsData hold.
- R10: doneStrobe is high for exactly the one cycle after the last pixel byte transfers, with busy still high. busy is low in the cycle after that.
- R11: A startReq while busy is ignored: the byte stream in progress continues unchanged.
- R12: Changes on posX, posY or fgColor while busy have no effect on the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to render one glyph; sampled only while idle |
| posX | input | 16 | Left column of the cell |
| posY | input | 16 | Top row of the cell |
| fgColor | input | 24 | Foreground colour, red in bits 23:16, green in bits 15:8, blue in bits 7:0 |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| romAddr | output | 7 | Glyph byte address |
| romData | input | 8 | Glyph byte, valid one cycle after romAddr |
| outValid | output | 1 | outByte and outIsData are valid |
| outReady | input | 1 | Downstream accepts the byte |
| outIsData | output | 1 | 1 for a data byte, 0 for a command byte |
| outByte | output | 8 | Command or data byte |
| doneStrobe | output | 1 | One-cycle pulse after the final byte |

## Verification
A bad header counter shows at once as a wrong byte or command flag within the first eleven transfers. A bad bit or lane counter corrupts the first pixel byte it touches, so the reference queue flags it on that same transfer. A bad glyph-address counter puts romAddr off the running count of emitted pixels within one cycle. Even when its data happens to match, it fails the address comparison. A bad end-of-run decode shows as a done pulse that comes early or late against the drained queue, or a byte left over in the queue.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int COORD_W  = 16;
  localparam int CHAN_W   = 8;
  localparam int NUM_CHAN = 3;
  localparam int HDR_LEN  = 11;

  localparam logic [7:0] OP_COLWIN = 8'h2A;
  localparam logic [7:0] OP_ROWWIN = 8'h2B;
  localparam logic [7:0] OP_MEMWR  = 8'h2C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_FETCH, ST_CAPT, ST_PIX, ST_DONE
  } phase_t;

  typedef struct packed {
    logic loadCfg;
    logic hdrStep;
    logic loadGlyph;
    logic pixStep;
    logic selPix;
  } dpCtrl_t;
endpackage

// File: rtl/glyph_dp.sv
module glyph_dp
  import glyph_pkg::*;
#(
  parameter int GLYPH_DIM = 32,
  localparam int BYTES_PER_ROW = GLYPH_DIM / 8,
  localparam int GLYPH_BYTES = GLYPH_DIM * BYTES_PER_ROW,
  localparam int ADDR_W = $clog2(GLYPH_BYTES),
  localparam int COLOR_W = NUM_CHAN * CHAN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctl,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [COLOR_W-1:0] fgColor,
  input  logic [7:0]         romData,
  output logic [ADDR_W-1:0]  romAddr,
  output logic               outIsData,
  output logic [7:0]         outByte,
  output logic               hdrLast,
  output logic               pixLast,
  output logic               glyphLast
);
  localparam int LANE_W = $clog2(NUM_CHAN);

  logic [COORD_W-1:0] xReg, yReg, xEnd, yEnd;
  logic [COLOR_W-1:0] fgReg;
  logic [3:0]         hdrIdx;
  logic [2:0]         bitIdx;
  logic [LANE_W-1:0]  lane;
  logic [ADDR_W-1:0]  byteIdx;
  logic [7:0]         glyphByte;
  logic               laneLast;

  assign xEnd = xReg + COORD_W'(GLYPH_DIM - 1);
  assign yEnd = yReg + COORD_W'(GLYPH_DIM - 1);

  assign romAddr   = byteIdx;
  assign hdrLast   = (hdrIdx == 4'(HDR_LEN - 1));
  assign laneLast  = (lane == LANE_W'(NUM_CHAN - 1));
  assign pixLast   = laneLast && (bitIdx == 3'd7);
  assign glyphLast = (byteIdx == ADDR_W'(GLYPH_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg      <= '0;
      yReg      <= '0;
      fgReg     <= '0;
      hdrIdx    <= '0;
      bitIdx    <= '0;
      lane      <= '0;
      byteIdx   <= '0;
      glyphByte <= '0;
    end else begin
      if (ctl.loadCfg) begin
        xReg    <= posX;
        yReg    <= posY;
        fgReg   <= fgColor;
        hdrIdx  <= '0;
        byteIdx <= '0;
      end
      if (ctl.hdrStep) hdrIdx <= hdrIdx + 4'd1;
      if (ctl.loadGlyph) begin
        glyphByte <= romData;
        bitIdx    <= '0;
        lane      <= '0;
      end
      if (ctl.pixStep) begin
        if (laneLast) begin
          lane <= '0;
          if (bitIdx == 3'd7) begin
            if (!glyphLast) byteIdx <= byteIdx + ADDR_W'(1);
          end else begin
            bitIdx <= bitIdx + 3'd1;
          end
        end else begin
          lane <= lane + LANE_W'(1);
        end
      end
    end
  end

  // Colour lanes, most significant channel first
  logic [CHAN_W-1:0] chanByte [NUM_CHAN];
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    assign chanByte[c] = fgReg[COLOR_W-1-c*CHAN_W -: CHAN_W];
  end

  logic       hdrFlag;
  logic [7:0] hdrByte;
  logic [7:0] pixByte;

  always_comb begin
    case (hdrIdx)
      4'd0:    {hdrFlag, hdrByte} = {1'b0, OP_COLWIN};
      4'd1:    {hdrFlag, hdrByte} = {1'b1, xReg[15:8]};
      4'd2:    {hdrFlag, hdrByte} = {1'b1, xReg[7:0]};
      4'd3:    {hdrFlag, hdrByte} = {1'b1, xEnd[15:8]};
      4'd4:    {hdrFlag, hdrByte} = {1'b1, xEnd[7:0]};
      4'd5:    {hdrFlag, hdrByte} = {1'b0, OP_ROWWIN};
      4'd6:    {hdrFlag, hdrByte} = {1'b1, yReg[15:8]};
      4'd7:    {hdrFlag, hdrByte} = {1'b1, yReg[7:0]};
      4'd8:    {hdrFlag, hdrByte} = {1'b1, yEnd[15:8]};
      4'd9:    {hdrFlag, hdrByte} = {1'b1, yEnd[7:0]};
      default: {hdrFlag, hdrByte} = {1'b0, OP_MEMWR};
    endcase
  end

  assign pixByte   = glyphByte[bitIdx] ? chanByte[lane] : '0;
  assign outIsData = ctl.selPix ? 1'b1 : hdrFlag;
  assign outByte   = ctl.selPix ? pixByte : hdrByte;
endmodule

// File: rtl/glyph_ctl.sv
module glyph_ctl
  import glyph_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    outReady,
  input  logic    hdrLast,
  input  logic    pixLast,
  input  logic    glyphLast,
  output dpCtrl_t ctl,
  output logic    outValid,
  output logic    busy,
  output logic    doneStrobe
);
  phase_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    outValid  = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (startReq) begin
        ctl.loadCfg = 1'b1;
        nextState   = ST_HDR;
      end
      ST_HDR: begin
        outValid = 1'b1;
        if (outReady) begin
          if (hdrLast) nextState   = ST_FETCH;
          else         ctl.hdrStep = 1'b1;
        end
      end
      ST_FETCH: nextState = ST_CAPT;
      ST_CAPT: begin
        ctl.loadGlyph = 1'b1;
        nextState     = ST_PIX;
      end
      ST_PIX: begin
        outValid   = 1'b1;
        ctl.selPix = 1'b1;
        if (outReady) begin
          ctl.pixStep = 1'b1;
          if (pixLast) nextState = glyphLast ? ST_DONE : ST_FETCH;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign doneStrobe = (state == ST_DONE);
endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
  import glyph_pkg::*;
#(
  parameter int GLYPH_DIM = 32,
  localparam int GLYPH_BYTES = GLYPH_DIM * (GLYPH_DIM / 8),
  localparam int ADDR_W = $clog2(GLYPH_BYTES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startReq,
  input  logic [COORD_W-1:0]           posX,
  input  logic [COORD_W-1:0]           posY,
  input  logic [NUM_CHAN*CHAN_W-1:0]   fgColor,
  output logic                         busy,
  output logic [ADDR_W-1:0]            romAddr,
  input  logic [7:0]                   romData,
  output logic                         outValid,
  input  logic                         outReady,
  output logic                         outIsData,
  output logic [7:0]                   outByte,
  output logic                         doneStrobe
);
  dpCtrl_t ctl;
  logic    hdrLast, pixLast, glyphLast;

  glyph_ctl u_ctl (
    .clk, .rstN, .startReq, .outReady, .hdrLast, .pixLast, .glyphLast,
    .ctl, .outValid, .busy, .doneStrobe
  );

  glyph_dp #(.GLYPH_DIM(GLYPH_DIM)) u_dp (
    .clk, .rstN, .ctl, .posX, .posY, .fgColor, .romData, .romAddr,
    .outIsData, .outByte, .hdrLast, .pixLast, .glyphLast
  );
endmodule

// File: rtl/glyph_expander_chk.sv
module glyph_expander_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              outReady,
  input logic              outValid,
  input logic              outIsData,
  input logic [7:0]        outByte,
  input logic              doneStrobe,
  input logic              busy,
  input logic [ADDR_W-1:0] romAddr
);
  AST_FIRST_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> outValid && !outIsData && outByte == 8'h2A); // R1

  AST_CMD_CODES: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outIsData |-> outByte == 8'h2A || outByte == 8'h2B || outByte == 8'h2C); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && busy && romAddr != $past(romAddr) |-> romAddr == $past(romAddr) + ADDR_W'(1)); // R5

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte) && $stable(outIsData)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe && !busy); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> busy && !outValid); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && startReq && !doneStrobe |=> busy); // R11
endmodule

bind glyph_expander glyph_expander_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/glyph_expander_bench.sv
module glyph_expander_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] posX = '0;
  logic [15:0] posY = '0;
  logic [23:0] fgColor = '0;
  logic        busy;
  logic [6:0]  romAddr;
  logic [7:0]  romData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        outIsData;
  logic [7:0]  outByte;
  logic        doneStrobe;

  glyph_expander u_glyph_expander (
    .clk, .rstN, .startReq, .posX, .posY, .fgColor, .busy, .romAddr,
    .romData, .outValid, .outReady, .outIsData, .outByte, .doneStrobe
  );

  always #2 clk = ~clk;

  logic [7:0] mem [128];
  always_ff @(posedge clk) romData <= mem[romAddr];

  int    nChecks = 0;
  int    nFail   = 0;
  int    cycles  = 0;
  bit    stallMode = 1'b0;
  bit    pendDone = 1'b0;
  bit    afterDone = 1'b0;
  int    pixPopped = 0;
  logic [8:0] expQ [$];
  string      tagQ [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // Reference stream built from the requirements
  task automatic buildStream();
    logic [15:0] xe, ye;
    xe = posX + 16'd31;
    ye = posY + 16'd31;
    expQ.delete(); tagQ.delete();
    expQ.push_back({1'b0, 8'h2A}); tagQ.push_back("R1");
    expQ.push_back({1'b1, posX[15:8]}); tagQ.push_back("R2");
    expQ.push_back({1'b1, posX[7:0]});  tagQ.push_back("R2");
    expQ.push_back({1'b1, xe[15:8]});   tagQ.push_back("R2");
    expQ.push_back({1'b1, xe[7:0]});    tagQ.push_back("R2");
    expQ.push_back({1'b0, 8'h2B});      tagQ.push_back("R3");
    expQ.push_back({1'b1, posY[15:8]}); tagQ.push_back("R3");
    expQ.push_back({1'b1, posY[7:0]});  tagQ.push_back("R3");
    expQ.push_back({1'b1, ye[15:8]});   tagQ.push_back("R3");
    expQ.push_back({1'b1, ye[7:0]});    tagQ.push_back("R3");
    expQ.push_back({1'b0, 8'h2C});      tagQ.push_back("R4");
    for (int b = 0; b < 128; b++) begin
      for (int k = 0; k < 8; k++) begin // R6: bit 0 first
        if (mem[b][k]) begin
          expQ.push_back({1'b1, fgColor[23:16]}); tagQ.push_back("R6/R7");
          expQ.push_back({1'b1, fgColor[15:8]});  tagQ.push_back("R6/R7");
          expQ.push_back({1'b1, fgColor[7:0]});   tagQ.push_back("R6/R7");
        end else begin
          for (int c = 0; c < 3; c++) begin
            expQ.push_back(9'h100); tagQ.push_back("R6/R8");
          end
        end
      end
    end
    pixPopped = 0;
  endtask

  // Monitor: samples away from the rising edge, inputs change 1 ns after it
  always @(negedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
    if (rstN) begin
      if (pendDone || doneStrobe)
        chk(doneStrobe == pendDone, "R10", "doneStrobe", doneStrobe, pendDone);
      if (afterDone)
        chk(busy == 1'b0, "R10", "busy after done", busy, 0);
      afterDone = pendDone;
      pendDone  = 1'b0;
      if (busy) begin
        int ea;
        ea = (pixPopped / 24 > 127) ? 127 : pixPopped / 24;
        chk(romAddr == 7'(ea), "R5", "romAddr", romAddr, ea);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4", "extra byte", {outIsData, outByte}, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({outIsData, outByte} == e, t, "byte", {outIsData, outByte}, e);
          if (expQ.size() < 3072) pixPopped++;
          if (expQ.size() == 0) pendDone = 1'b1;
        end
      end
      if (startReq && !busy) buildStream();
    end
  end

  // Downstream readiness: free-running or stalling pattern (R9)
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      outReady = stallMode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  task automatic startGlyph(input logic [15:0] x, input logic [15:0] y,
                            input logic [23:0] c);
    @(posedge clk); #1;
    posX = x; posY = y; fgColor = c; startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    @(posedge doneStrobe);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R4", "bytes left in stream", expQ.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(outValid == 1'b0, "R1", "outValid at reset", outValid, 0);
    chk(doneStrobe == 1'b0, "R1", "doneStrobe at reset", doneStrobe, 0);

    // Glyph A: mixed pattern, no back-pressure
    startGlyph(16'd10, 16'd20, 24'hC35A0F);
    waitDone();

    // Glyph B: carries in the end coordinates, stalls, ignored start (R11, R12)
    for (int i = 0; i < 128; i++)
      mem[i] = (i % 3 == 0) ? 8'hFF : ((i % 3 == 1) ? 8'h00 : 8'h81);
    stallMode = 1'b1;
    startGlyph(16'hFFF0, 16'h00F0, 24'h123456);
    repeat (200) @(posedge clk);
    #1;
    posX = 16'h0123; posY = 16'h0456; fgColor = 24'hFFFFFF; startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
    repeat (500) @(posedge clk);
    #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    waitDone();

    // Glyph C: all set bits at the origin, stalls
    for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
    startGlyph(16'h0000, 16'h0000, 24'h0080FE);
    waitDone();

    // Glyph D: all clear bits, bright colour must not appear (R8)
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    stallMode = 1'b0;
    startGlyph(16'h00E1, 16'h0121, 24'hFFFFFF);
    waitDone();

    finishRun();
  end
endmodule